// File: doc/BRIEF.md
# Write-Back Data Cache Controller with Split Dirty Tracking

This block controls a set-associative data cache. It is indexed and tagged with virtual addresses. For each line it also keeps the physical line address that the line was filled from. The CPU side presents one access at a time:

- the virtual address;
- the translated physical address;
- a cacheable flag and a bufferable flag, which together choose uncached, write-through or write-back handling;
- an abort flag from the translation stage.

An external replacement selector names the victim way for each access. A maintenance port cleans one line, chosen by set and way.

Line storage is split into two 4-word halves, and each half has its own dirty flag. When a line is evicted or cleaned, the controller writes back only the halves that were modified. It writes them to the stored physical address, never to the address of the current request. A linefill always reads the whole 8-word line. Only load misses allocate a line.

The memory port is a beat-level request/ready interface. Every beat carries its own byte address. The first beat of a burst is flagged and carries the burst length.

Top module: `wbcache_ctrl`

## Requirements
- R1: Address fields are word offset = vaddr[4:2], set = vaddr[7:5] and tag = vaddr[31:8]. The default geometry is 8 sets of 64 ways, with 8 words per line. A load that hits returns the cached word and produces no memory beat.
- R2: A load miss with cacheable=1 performs a linefill and returns the requested word.
  - The linefill is 8 read beats from the physical line base (paddr with bits [4:0] cleared), in ascending word order.
  - The first beat has mem_first=1 and mem_len=8.
  - The line is installed in way victim_way.
- R3: A store hit with cacheable=1 and bufferable=1 updates the cached word and produces no memory beat. It sets the dirty flag of the half that holds the word: words 0-3 are the low half and words 4-7 are the high half.
- R4: A store hit with cacheable=1 and bufferable=0 updates the cached word, issues one write beat to paddr, and leaves the dirty flags unchanged.
- R5: A store miss issues one write beat to paddr and allocates nothing.
- R6: Before a linefill replaces a valid line, the dirty halves of the victim are written back.
  - One dirty half: 4 beats with mem_len=4, starting at the stored base plus 0 (low half) or plus 16 (high half).
  - Both halves dirty: one 8-beat burst from the base with mem_len=8.
  - Clean victim: no write beat.
- R7: Write-back addresses come from the physical line base stored at fill time, whatever paddr the current request carries.
- R8: A clean request (clean_set, clean_way) writes back the dirty halves as in R6. It then clears both dirty flags and keeps the line valid. A clean or invalid line produces no beat.
- R9: An access with abort=1 completes with op_done in the next cycle. It produces no memory beat and changes no cache state.
- R10: An access with cacheable=0 is one beat (mem_len=1) to paddr and allocates nothing.
- R11: Handshake rules.
  - Requests are accepted only while busy=0, and busy is high until completion.
  - op_done is a one-cycle pulse.
  - A memory beat holds its address and direction until mem_ready.
  - mem_req is low while idle.
- R12: After reset no line is valid, busy=0, op_done=0 and mem_req=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_vaddr | input | 32 | Virtual byte address |
| cpu_paddr | input | 32 | Translated physical byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_cacheable | input | 1 | Region may be cached |
| cpu_bufferable | input | 1 | With cacheable: write-back, else write-through |
| cpu_abort | input | 1 | Access aborted by translation |
| victim_way | input | 6 | Way to replace on a load miss |
| clean_req | input | 1 | Clean one line |
| clean_set | input | 3 | Set of the line to clean |
| clean_way | input | 6 | Way of the line to clean |
| busy | output | 1 | Operation in progress |
| op_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load result, valid with op_done |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Write beat data |
| mem_first | output | 1 | First beat of a burst |
| mem_len | output | 4 | Burst length in beats, valid with mem_first |
| mem_ready | input | 1 | Beat accepted |
| mem_rdata | input | 32 | Read beat data |

## Verification
The hardest case to reach is an eviction where the stored physical address and the current translation disagree. The line must be dirty in one half only, and the replacement must come from a different virtual tag in the same set with the same victim way.

The stimulus builds this in three steps:
1. Fill a line.
2. Store into its high half while presenting a different paddr, which a hit ignores.
3. Load a new tag in the same set with the same victim_way.

The bench then checks that the 4-beat write burst lands at the original base plus 16 and comes before the 8-beat fill. A sequence of clean requests with low-only, both-halves and no dirty data covers the other outcomes of the half-line write-back.

// File: rtl/wbcache_pkg.sv
package wbcache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FILL,
    ST_SINGLE,
    ST_RESP
  } wbc_state_t;
endpackage

// File: rtl/wbcache_rst_sync.sv
module wbcache_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/wbcache_way_match.sv
module wbcache_way_match #(
  parameter int WAYS  = 64,
  parameter int TAG_W = 24,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             valid_row,
  input  logic [WAYS-1:0][TAG_W-1:0]  tag_row,
  input  logic [TAG_W-1:0]            look_tag,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way
);
  logic [WAYS-1:0] match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = valid_row[g] && (tag_row[g] == look_tag);
  end

  // lowest matching way wins (only one can match in normal use)
  always_comb begin
    hit     = |match;
    hit_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match[i]) hit_way = WAY_W'(i);
    end
  end
endmodule

// File: rtl/wbcache_ctrl.sv
module wbcache_ctrl
  import wbcache_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int SETS       = 8,
  parameter int WAYS       = 64,
  parameter int LINE_WORDS = 8,
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int OFF_W   = $clog2(LINE_WORDS),
  localparam int LEN_W   = OFF_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_vaddr,
  input  logic [AW-1:0]    cpu_paddr,
  input  logic [DW-1:0]    cpu_wdata,
  input  logic             cpu_cacheable,
  input  logic             cpu_bufferable,
  input  logic             cpu_abort,
  input  logic [WAY_W-1:0] victim_way,
  input  logic             clean_req,
  input  logic [SET_W-1:0] clean_set,
  input  logic [WAY_W-1:0] clean_way,
  output logic             busy,
  output logic             op_done,
  output logic [DW-1:0]    cpu_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             mem_first,
  output logic [LEN_W-1:0] mem_len,
  input  logic             mem_ready,
  input  logic [DW-1:0]    mem_rdata
);
  localparam int SET_LSB = 2 + OFF_W;
  localparam int TAG_LSB = SET_LSB + SET_W;
  localparam int TAG_W   = AW - TAG_LSB;
  localparam int PA_W    = AW - SET_LSB;
  localparam int LINES   = SETS * WAYS;
  localparam int HALF    = LINE_WORDS / 2;
  localparam int LIDX_W  = SET_W + WAY_W;

  logic core_rst_n;

  wbcache_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(core_rst_n));

  // request capture
  wbc_state_t       state_q, state_d;
  logic [OFF_W-1:0] cnt_q, cnt_d;
  logic             r_clean, r_we, r_c, r_b;
  logic [SET_W-1:0] r_set;
  logic [WAY_W-1:0] r_way;
  logic [OFF_W-1:0] r_off;
  logic [TAG_W-1:0] r_tag;
  logic [AW-3:0]    r_pword;
  logic [DW-1:0]    r_wdata;
  logic             wb_lo_q, wb_hi_q;
  logic [PA_W-1:0]  wb_base_q;
  logic [DW-1:0]    rdata_q, rdata_d;

  // storage
  logic [SETS-1:0][WAYS-1:0] valid_q, dlo_q, dhi_q;
  logic [TAG_W-1:0] tag_mem  [LINES];
  logic [PA_W-1:0]  pa_mem   [LINES];
  logic [DW-1:0]    data_mem [LINES*LINE_WORDS];

  // control strobes
  logic cap_en, cap_clean, way_upd, wb_set, rdata_en;
  logic dwr_en, fill_done, clean_done, mark_lo, mark_hi;
  logic [LIDX_W+OFF_W-1:0] dwr_idx;
  logic [DW-1:0]           dwr_val;

  // lookup
  logic [WAYS-1:0][TAG_W-1:0] tag_row;
  logic                       hit;
  logic [WAY_W-1:0]           hit_way, line_way;
  logic [LIDX_W-1:0]          line_idx;
  logic                       cur_valid, cur_dlo, cur_dhi;
  logic [DW-1:0]              rd_word;
  logic [OFF_W-1:0]           wb_start, wb_end, rd_off;
  logic                       unused_addr_bits;

  assign unused_addr_bits = ^{cpu_vaddr[1:0], cpu_paddr[1:0]};

  always_comb begin
    for (int w = 0; w < WAYS; w++) tag_row[w] = tag_mem[{r_set, WAY_W'(w)}];
  end

  wbcache_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .valid_row (valid_q[r_set]),
    .tag_row   (tag_row),
    .look_tag  (r_tag),
    .hit       (hit),
    .hit_way   (hit_way)
  );

  assign line_way  = (state_q == ST_LOOK && !r_clean && hit) ? hit_way : r_way;
  assign line_idx  = {r_set, line_way};
  assign cur_valid = valid_q[r_set][line_way];
  assign cur_dlo   = dlo_q[r_set][line_way];
  assign cur_dhi   = dhi_q[r_set][line_way];
  assign rd_off    = (state_q == ST_WB) ? cnt_q : r_off;
  assign rd_word   = data_mem[{line_idx, rd_off}];
  assign wb_start  = wb_lo_q ? '0 : OFF_W'(HALF);
  assign wb_end    = wb_hi_q ? OFF_W'(LINE_WORDS - 1) : OFF_W'(HALF - 1);

  assign busy      = (state_q != ST_IDLE);
  assign op_done   = (state_q == ST_RESP);
  assign cpu_rdata = rdata_q;

  // next state and strobes
  always_comb begin
    state_d = state_q;  cnt_d = cnt_q;
    cap_en = 1'b0;  cap_clean = 1'b0;  way_upd = 1'b0;  wb_set = 1'b0;
    rdata_en = 1'b0;  rdata_d = rdata_q;
    dwr_en = 1'b0;  dwr_idx = {line_idx, r_off};  dwr_val = r_wdata;
    fill_done = 1'b0;  clean_done = 1'b0;  mark_lo = 1'b0;  mark_hi = 1'b0;
    mem_req = 1'b0;  mem_we = 1'b0;  mem_addr = '0;  mem_wdata = rd_word;
    mem_first = 1'b0;  mem_len = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (clean_req) begin
          cap_en = 1'b1;  cap_clean = 1'b1;  state_d = ST_LOOK;
        end else if (cpu_req) begin
          cap_en  = 1'b1;
          state_d = cpu_abort ? ST_RESP : ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (r_clean) begin
          if (cur_valid && (cur_dlo || cur_dhi)) begin
            wb_set = 1'b1;  cnt_d = cur_dlo ? '0 : OFF_W'(HALF);  state_d = ST_WB;
          end else begin
            clean_done = 1'b1;  state_d = ST_RESP;
          end
        end else if (!r_c) begin
          state_d = ST_SINGLE;
        end else if (hit) begin
          way_upd = 1'b1;
          if (!r_we) begin
            rdata_en = 1'b1;  rdata_d = rd_word;  state_d = ST_RESP;
          end else begin
            dwr_en = 1'b1;
            if (r_b) begin
              mark_lo = !r_off[OFF_W-1];  mark_hi = r_off[OFF_W-1];  state_d = ST_RESP;
            end else begin
              state_d = ST_SINGLE;
            end
          end
        end else if (r_we) begin
          state_d = ST_SINGLE;
        end else if (cur_valid && (cur_dlo || cur_dhi)) begin
          wb_set = 1'b1;  cnt_d = cur_dlo ? '0 : OFF_W'(HALF);  state_d = ST_WB;
        end else begin
          cnt_d = '0;  state_d = ST_FILL;
        end
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {wb_base_q, cnt_q, 2'b00};
        mem_first = (cnt_q == wb_start);
        mem_len   = (wb_lo_q && wb_hi_q) ? LEN_W'(LINE_WORDS) : LEN_W'(HALF);
        if (mem_ready) begin
          if (cnt_q == wb_end) begin
            if (r_clean) begin
              clean_done = 1'b1;  state_d = ST_RESP;
            end else begin
              cnt_d = '0;  state_d = ST_FILL;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_FILL: begin
        mem_req   = 1'b1;
        mem_addr  = {r_pword[AW-3:OFF_W], cnt_q, 2'b00};
        mem_first = (cnt_q == '0);
        mem_len   = LEN_W'(LINE_WORDS);
        if (mem_ready) begin
          dwr_en = 1'b1;  dwr_idx = {line_idx, cnt_q};  dwr_val = mem_rdata;
          if (cnt_q == r_off) begin
            rdata_en = 1'b1;  rdata_d = mem_rdata;
          end
          if (cnt_q == OFF_W'(LINE_WORDS - 1)) begin
            fill_done = 1'b1;  state_d = ST_RESP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_SINGLE: begin
        mem_req   = 1'b1;
        mem_we    = r_we;
        mem_addr  = {r_pword, 2'b00};
        mem_wdata = r_wdata;
        mem_first = 1'b1;
        mem_len   = LEN_W'(1);
        if (mem_ready) begin
          if (!r_we) begin
            rdata_en = 1'b1;  rdata_d = mem_rdata;
          end
          state_d = ST_RESP;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // line state flags
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      valid_q <= '0;
      dlo_q   <= '0;
      dhi_q   <= '0;
    end else begin
      if (fill_done) valid_q[r_set][r_way] <= 1'b1;
      if (fill_done || clean_done) begin
        dlo_q[r_set][r_way] <= 1'b0;
        dhi_q[r_set][r_way] <= 1'b0;
      end else begin
        if (mark_lo) dlo_q[r_set][line_way] <= 1'b1;
        if (mark_hi) dhi_q[r_set][line_way] <= 1'b1;
      end
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    if (cap_en) begin
      r_clean <= cap_clean;
      r_set   <= cap_clean ? clean_set : cpu_vaddr[SET_LSB +: SET_W];
      r_way   <= cap_clean ? clean_way : victim_way;
      r_we    <= cpu_we;
      r_c     <= cpu_cacheable;
      r_b     <= cpu_bufferable;
      r_off   <= cpu_vaddr[2 +: OFF_W];
      r_tag   <= cpu_vaddr[AW-1:TAG_LSB];
      r_pword <= cpu_paddr[AW-1:2];
      r_wdata <= cpu_wdata;
    end else if (way_upd) begin
      r_way <= hit_way;
    end
    if (wb_set) begin
      wb_lo_q   <= cur_dlo;
      wb_hi_q   <= cur_dhi;
      wb_base_q <= pa_mem[line_idx];
    end
    if (rdata_en) rdata_q <= rdata_d;
  end

  always_ff @(posedge clk) begin
    if (dwr_en) data_mem[dwr_idx] <= dwr_val;
    if (fill_done) begin
      tag_mem[line_idx] <= r_tag;
      pa_mem[line_idx]  <= r_pword[AW-3:OFF_W];
    end
  end
endmodule

// File: rtl/wbcache_ctrl_checker.sv
module wbcache_ctrl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_abort,
  input logic        clean_req,
  input logic        busy,
  input logic        op_done,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ready,
  input logic        mem_first,
  input logic [3:0]  mem_len,
  input logic [31:0] mem_addr
);
  assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_abort && !clean_req && !busy) |=> (op_done && !mem_req));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_beat_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_half_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_first && mem_len == 4'd4) |-> (mem_addr[3:0] == 4'd0));

  assert_full_wb_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_first && mem_len == 4'd8) |-> (mem_addr[4:0] == 5'd0));

  assert_fill_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_first && mem_len == 4'd8) |-> (mem_addr[4:0] == 5'd0));
endmodule

bind wbcache_ctrl wbcache_ctrl_checker u_chk (
  .clk       (clk),
  .rst_n     (core_rst_n),
  .cpu_req   (cpu_req),
  .cpu_abort (cpu_abort),
  .clean_req (clean_req),
  .busy      (busy),
  .op_done   (op_done),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ready (mem_ready),
  .mem_first (mem_first),
  .mem_len   (mem_len),
  .mem_addr  (mem_addr)
);

// File: tb/wbcache_ctrl_test.sv
module wbcache_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_vaddr = '0, cpu_paddr = '0, cpu_wdata = '0;
  logic        cpu_cacheable = 1'b0, cpu_bufferable = 1'b0, cpu_abort = 1'b0;
  logic [5:0]  victim_way = '0;
  logic        clean_req = 1'b0;
  logic [2:0]  clean_set = '0;
  logic [5:0]  clean_way = '0;
  logic        busy, op_done, mem_req, mem_we, mem_first, mem_ready;
  logic [31:0] cpu_rdata, mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_len;

  logic [31:0] mem_model [256];
  int          rd_n, wr_n;
  logic [31:0] rd_a0, wr_a0;
  logic [3:0]  rd_len0, wr_len0;
  int          checks = 0, failures = 0;
  int          pulse_len;
  logic        busy_seen;

  always #2.5 clk = ~clk;

  assign mem_ready = mem_req;
  assign mem_rdata = mem_model[mem_addr[9:2]];

  wbcache_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_vaddr(cpu_vaddr), .cpu_paddr(cpu_paddr), .cpu_wdata(cpu_wdata),
    .cpu_cacheable(cpu_cacheable), .cpu_bufferable(cpu_bufferable),
    .cpu_abort(cpu_abort), .victim_way(victim_way), .clean_req(clean_req),
    .clean_set(clean_set), .clean_way(clean_way), .busy(busy),
    .op_done(op_done), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_first(mem_first), .mem_len(mem_len), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'hA5A5_0000 ^ a;
  endfunction

  // memory model and beat log
  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ready) begin
      if (mem_we) begin
        mem_model[mem_addr[9:2]] <= mem_wdata;
        if (wr_n == 0) begin wr_a0 <= mem_addr; wr_len0 <= mem_len; end
        wr_n <= wr_n + 1;
      end else begin
        if (rd_n == 0) begin rd_a0 <= mem_addr; rd_len0 <= mem_len; end
        rd_n <= rd_n + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk);
    rd_n = 0;  wr_n = 0;
  endtask

  task automatic wait_done(output logic [31:0] rd);
    @(negedge clk);
    busy_seen = busy;
    while (!op_done) @(negedge clk);
    rd = cpu_rdata;
    pulse_len = 1;
    @(negedge clk);
    if (op_done) pulse_len = 2;
  endtask

  task automatic access(input logic we, input logic [31:0] va, input logic [31:0] pa,
                        input logic [31:0] wd, input logic c, input logic b,
                        input logic ab, input logic [5:0] vic, output logic [31:0] rd);
    clear_log();
    cpu_we = we;  cpu_vaddr = va;  cpu_paddr = pa;  cpu_wdata = wd;
    cpu_cacheable = c;  cpu_bufferable = b;  cpu_abort = ab;  victim_way = vic;
    cpu_req = 1'b1;
    @(negedge clk);
    cpu_req = 1'b0;
    busy_seen = busy;
    while (!op_done) @(negedge clk);
    rd = cpu_rdata;
    pulse_len = 1;
    @(negedge clk);
    if (op_done) pulse_len = 2;
  endtask

  task automatic clean(input logic [2:0] s, input logic [5:0] w);
    logic [31:0] dummy;
    clear_log();
    clean_set = s;  clean_way = w;  clean_req = 1'b1;
    @(negedge clk);
    clean_req = 1'b0;
    while (!op_done) @(negedge clk);
    dummy = cpu_rdata;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R12 busy", 32'(busy), 32'd0);
    check("R12 op_done", 32'(op_done), 32'd0);
    check("R12 mem_req", 32'(mem_req), 32'd0);
  endtask

  task automatic t_fill_and_hit();
    logic [31:0] rd;
    access(1'b0, 32'h1000_0024, 32'h0000_0124, '0, 1'b1, 1'b1, 1'b0, 6'd5, rd);
    check("R2 fill data", rd, pat(32'h124));
    check("R2 fill beats", 32'(rd_n), 32'd8);
    check("R2 fill base", rd_a0, 32'h120);
    check("R2 fill len", 32'(rd_len0), 32'd8);
    check("R11 busy after accept", 32'(busy_seen), 32'd1);
    check("R11 done pulse", 32'(pulse_len), 32'd1);
    access(1'b0, 32'h1000_0038, 32'h0000_0138, '0, 1'b1, 1'b1, 1'b0, 6'd9, rd);
    check("R1 hit data", rd, pat(32'h138));
    check("R1 hit no beats", 32'(rd_n + wr_n), 32'd0);
  endtask

  task automatic t_wb_store_clean();
    logic [31:0] rd;
    access(1'b1, 32'h1000_0024, 32'h0000_0124, 32'hDEAD_0001, 1'b1, 1'b1, 1'b0, 6'd0, rd);
    check("R3 store hit no beats", 32'(rd_n + wr_n), 32'd0);
    access(1'b0, 32'h1000_0024, 32'h0000_0124, '0, 1'b1, 1'b1, 1'b0, 6'd0, rd);
    check("R3 stored word", rd, 32'hDEAD_0001);
    clean(3'd1, 6'd5);
    check("R8 low half beats", 32'(wr_n), 32'd4);
    check("R8 low half addr", wr_a0, 32'h120);
    check("R6 half len", 32'(wr_len0), 32'd4);
    check("R8 memory updated", mem_model[32'h124 >> 2], 32'hDEAD_0001);
    clean(3'd1, 6'd5);
    check("R8 dirty cleared", 32'(wr_n), 32'd0);
    access(1'b0, 32'h1000_0024, 32'h0000_0124, '0, 1'b1, 1'b1, 1'b0, 6'd3, rd);
    check("R8 still valid", 32'(rd_n), 32'd0);
    check("R8 still valid data", rd, 32'hDEAD_0001);
  endtask

  task automatic t_stored_pa_evict();
    logic [31:0] rd;
    // translation now differs; hit still marks high half dirty
    access(1'b1, 32'h1000_0038, 32'h0000_03F8, 32'hBEEF_0006, 1'b1, 1'b1, 1'b0, 6'd0, rd);
    access(1'b0, 32'h2000_0024, 32'h0000_0224, '0, 1'b1, 1'b1, 1'b0, 6'd5, rd);
    check("R6 high half beats", 32'(wr_n), 32'd4);
    check("R7 stored base plus 16", wr_a0, 32'h130);
    check("R7 data at stored PA", mem_model[32'h138 >> 2], 32'hBEEF_0006);
    check("R6 fill after wb", 32'(rd_n), 32'd8);
    check("R6 new line data", rd, pat(32'h224));
  endtask

  task automatic t_both_dirty();
    logic [31:0] rd;
    access(1'b1, 32'h2000_0020, 32'h0000_0220, 32'h1111_0000, 1'b1, 1'b1, 1'b0, 6'd0, rd);
    access(1'b1, 32'h2000_003C, 32'h0000_023C, 32'h2222_0007, 1'b1, 1'b1, 1'b0, 6'd0, rd);
    clean(3'd1, 6'd5);
    check("R6 full beats", 32'(wr_n), 32'd8);
    check("R6 full addr", wr_a0, 32'h220);
    check("R6 full len", 32'(wr_len0), 32'd8);
    check("R6 word0 written", mem_model[32'h220 >> 2], 32'h1111_0000);
    check("R6 word7 written", mem_model[32'h23C >> 2], 32'h2222_0007);
  endtask

  task automatic t_write_through();
    logic [31:0] rd;
    access(1'b1, 32'h2000_0028, 32'h0000_0228, 32'h3333_0002, 1'b1, 1'b0, 1'b0, 6'd0, rd);
    check("R4 wt beats", 32'(wr_n), 32'd1);
    check("R4 wt addr", wr_a0, 32'h228);
    check("R4 wt memory", mem_model[32'h228 >> 2], 32'h3333_0002);
    clean(3'd1, 6'd5);
    check("R4 dirty unchanged", 32'(wr_n), 32'd0);
    access(1'b0, 32'h2000_0028, 32'h0000_0228, '0, 1'b1, 1'b1, 1'b0, 6'd0, rd);
    check("R4 cache updated", rd, 32'h3333_0002);
    check("R4 cache hit", 32'(rd_n), 32'd0);
  endtask

  task automatic t_store_miss();
    logic [31:0] rd;
    access(1'b1, 32'h3000_0044, 32'h0000_0344, 32'h4444_0001, 1'b1, 1'b1, 1'b0, 6'd0, rd);
    check("R5 miss write beats", 32'(wr_n), 32'd1);
    check("R5 miss write addr", wr_a0, 32'h344);
    check("R5 miss no read", 32'(rd_n), 32'd0);
    access(1'b0, 32'h3000_0044, 32'h0000_0344, '0, 1'b1, 1'b1, 1'b0, 6'd0, rd);
    check("R5 not allocated", 32'(rd_n), 32'd8);
    check("R5 memory data", rd, 32'h4444_0001);
  endtask

  task automatic t_abort();
    logic [31:0] rd;
    access(1'b0, 32'h4000_0064, 32'h0000_0164, '0, 1'b1, 1'b1, 1'b1, 6'd1, rd);
    check("R9 no beats", 32'(rd_n + wr_n), 32'd0);
    check("R9 done pulse", 32'(pulse_len), 32'd1);
    access(1'b0, 32'h4000_0064, 32'h0000_0164, '0, 1'b1, 1'b1, 1'b0, 6'd1, rd);
    check("R9 no allocation", 32'(rd_n), 32'd8);
    check("R9 later fill data", rd, pat(32'h164));
  endtask

  task automatic t_uncached();
    logic [31:0] rd;
    access(1'b0, 32'h5000_0084, 32'h0000_0184, '0, 1'b0, 1'b0, 1'b0, 6'd2, rd);
    check("R10 one beat", 32'(rd_n), 32'd1);
    check("R10 len", 32'(rd_len0), 32'd1);
    check("R10 data", rd, pat(32'h184));
    access(1'b0, 32'h5000_0084, 32'h0000_0184, '0, 1'b0, 1'b0, 1'b0, 6'd2, rd);
    check("R10 not allocated", 32'(rd_n), 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem_model[i] = pat(32'(i * 4));
    rd_n = 0;  wr_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fill_and_hit();
    t_wb_store_clean();
    t_stored_pa_evict();
    t_both_dirty();
    t_write_through();
    t_store_miss();
    t_abort();
    t_uncached();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog R11 actual=hung expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule